// File: doc/BRIEF.md
# Transmit Frame FIFO

This block collects an outgoing Ethernet frame, one 32-bit word at a time, into a 2048-byte staging buffer. It then replays the frame as a byte stream. The first word written into an empty buffer is a header. Its low 16 bits give the payload length, and its upper 16 bits are the first two frame bytes. Every word after that carries four more frame bytes. The buffer keeps bytes in arrival order, least significant byte of each word first.

The block launches a frame on one of two triggers:
- **Automatic launch.** After a word write, the buffered byte count satisfies both a completeness rule and a programmable fill threshold. The completeness rule depends on whether the checksum is appended downstream.
- **Forced launch.** A one-cycle send request arrives, whatever the fill level.

During a launch the block emits the payload length plus 14 bytes, starting just after the 2-byte length prefix, at one byte per cycle. The final byte is marked as last. Short frames can be zero-padded to the minimum frame size. While a frame streams out, word writes are held off. When the frame ends, the buffer is emptied and a transmit-empty flag is raised. A length header that is too large is refused and raises a transmit-error flag. Acknowledging that flag also empties the buffer.

Top module: `tx_frame_fifo`

## Requirements
- R1: When the buffer is empty, a written word whose bits [15:0] exceed 2032 is discarded and `tx_err` is set in the next cycle. A length of exactly 2032 is accepted and leaves `tx_err` unchanged.
- R2: An accepted word occupies four buffer bytes, with bits [7:0] in the lowest address. A word is stored only when at least four of the 2048 bytes are free; otherwise it is dropped.
- R3: A frame counts as complete when the buffered byte count is at least the payload length plus 16. When `crc_auto` is 0, 4 more bytes are required. The requirement never exceeds 2048.
- R4: The fill threshold passes only when `thr_code` is below 63 and the byte count is at least 4 × (8 × `thr_code` + 1). A code of 63 disables it.
- R5: A word write that leaves both the threshold and the completeness check passing launches the frame. A write that leaves either failing launches nothing.
- R6: A cycle with `send_req` high while idle launches the buffered frame regardless of fill.
- R7: A launch streams payload length + 14 bytes, starting at buffer byte 2, with one byte per cycle on consecutive cycles. The first byte is valid in the cycle after the launching edge, and `out_last` marks only the final byte. Buffered checksum bytes beyond that length are not sent.
- R8: With `pad_en` set, a frame shorter than 60 bytes is sent as exactly 60 bytes, and every byte past the real length is zero. The sent length never exceeds 2046.
- R9: The clock edge that emits the last byte empties the buffer and sets `tx_empty`. `empty_ack` clears `tx_empty`.
- R10: `err_ack` clears `tx_err` and empties the buffer, so the next word written is taken as a new length header.
- R11: `wr_ready` is low from the cycle after a launch until the last byte is emitted.
- R12: After reset, `wr_ready` is 1 and `out_valid`, `tx_err` and `tx_empty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A word is offered on `wr_data` |
| wr_data | input | 32 | Header or frame word |
| wr_ready | output | 1 | Word writes are accepted (low while streaming) |
| send_req | input | 1 | Force a launch of the buffered frame |
| crc_auto | input | 1 | 1: checksum appended downstream, no CRC bytes expected in the buffer |
| pad_en | input | 1 | Zero-pad short frames to 60 bytes |
| thr_code | input | 6 | Fill threshold code, 63 = disabled |
| err_ack | input | 1 | Clear `tx_err` and empty the buffer |
| empty_ack | input | 1 | Clear `tx_empty` |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| tx_empty | output | 1 | A frame has been sent |
| tx_err | output | 1 | An oversize length header was refused |

## Verification
Each result has a fixed latency:
- `tx_err` changes at the edge that takes the offending word.
- The launch happens at the edge that takes the completing word or the send request.
- The first byte shows one cycle after the launch, and then one byte appears per cycle.
- The last byte and `tx_empty` arrive together.
- `wr_ready` falls from the cycle after the launch.

The bench drives and samples on the falling edge. Each byte it expects is queued before the edge that launches the frame, so the monitor can compare every valid byte in order. A byte that appears with nothing queued, or a queued byte that never appears, counts as a mismatch. Flag and ready checks are made at the first falling edge after the edge that should have changed them.

// File: rtl/tff_pkg.sv
// Shared constants and types for the transmit frame FIFO.
// Assumes 32-bit words and a 2-byte length prefix ahead of the frame.
package tff_pkg;
    localparam int WORD_BYTES   = 4;   // bytes per written word
    localparam int PREFIX_BYTES = 2;   // length prefix ahead of the frame
    localparam int HDR_BYTES    = 14;  // addresses and type not counted in length
    localparam int CRC_BYTES    = 4;   // checksum space when not appended downstream
    localparam int THR_GRAIN    = 8;   // words per threshold code step

    typedef enum logic [0:0] {
        EMIT_IDLE = 1'b0,
        EMIT_RUN  = 1'b1
    } emit_state_e;
endpackage

// File: rtl/tff_store.sv
// Word-write side of the FIFO: length header check, byte buffer, fill count.
// Stores each accepted word as four bytes, lowest byte first. Assumes the
// caller only raises wr_en while no frame is streaming out.
module tff_store
    import tff_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_PAY   = 2032,
    parameter int LEN_W     = 16,
    parameter int DATA_W    = 32,
    localparam int CNT_W    = $clog2(BUF_BYTES + 1),
    localparam int IDX_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flush,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              stored,
    output logic              reject,
    output logic [CNT_W-1:0]  fill_nxt,
    output logic [LEN_W-1:0]  len_nxt,
    output logic [7:0]        rd_byte
);
    localparam int WORDS = BUF_BYTES / WORD_BYTES;
    localparam int SUB_W = $clog2(WORD_BYTES);

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [CNT_W-1:0]  fill_q;
    logic [LEN_W-1:0]  len_q;
    logic              first_word;
    logic              too_long;
    logic              has_room;

    // Classify the offered word: header check and space check.
    always_comb begin
        first_word = (fill_q == '0);
        too_long   = first_word && (wr_data[LEN_W-1:0] > LEN_W'(MAX_PAY));
        has_room   = (fill_q <= CNT_W'(BUF_BYTES - WORD_BYTES));
        reject     = wr_en && too_long;
        stored     = wr_en && !too_long && has_room;
    end

    // Next fill count and payload length as seen after this edge.
    always_comb begin
        if (flush)       fill_nxt = '0;
        else if (stored) fill_nxt = fill_q + CNT_W'(WORD_BYTES);
        else             fill_nxt = fill_q;
        len_nxt = (stored && first_word) ? wr_data[LEN_W-1:0] : len_q;
    end

    // Fill count and latched payload length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            len_q  <= '0;
        end else begin
            fill_q <= fill_nxt;
            len_q  <= len_nxt;
        end
    end

    // Word storage; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (stored) mem_q[fill_q[IDX_W-1:SUB_W]] <= wr_data;
    end

    // Byte read port for the emitter.
    always_comb rd_byte = mem_q[rd_idx[IDX_W-1:SUB_W]][{rd_idx[SUB_W-1:0], 3'b000} +: 8];

    // R1: a refused header leaves the buffer empty.
    assert_reject_keeps_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_q == '0 && wr_data[LEN_W-1:0] > LEN_W'(MAX_PAY) && !flush) |=> (fill_q == '0));

    // R2: a word offered to a full buffer does not change the count.
    assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_q > CNT_W'(BUF_BYTES - WORD_BYTES) && !flush) |=> (fill_q == $past(fill_q)));
endmodule

// File: rtl/tff_launch.sv
// Launch decision: frame completeness (checksum mode aware, capped at the
// buffer size) combined with the coded fill threshold. Pure combinational;
// assumes fill and pay_len are the values after the current write.
module tff_launch
    import tff_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 16,
    parameter int THR_W     = 6,
    parameter int CNT_W     = 12
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [LEN_W-1:0] pay_len,
    input  logic             crc_auto,
    input  logic [THR_W-1:0] thr_code,
    output logic             go
);
    logic [31:0] need_raw;
    logic [31:0] need;
    logic [31:0] thr_bytes;
    logic        complete;
    logic        thr_ok;

    // Evaluate both launch conditions.
    always_comb begin
        need_raw  = 32'(pay_len) + 32'(PREFIX_BYTES + HDR_BYTES)
                  + (crc_auto ? 32'd0 : 32'(CRC_BYTES));
        need      = (need_raw > 32'(BUF_BYTES)) ? 32'(BUF_BYTES) : need_raw;
        complete  = (32'(fill) >= need);
        thr_bytes = 32'(WORD_BYTES) * (32'(thr_code) * 32'(THR_GRAIN) + 32'd1);
        thr_ok    = (thr_code != '1) && (32'(fill) >= thr_bytes);
        go        = complete && thr_ok;
    end
endmodule

// File: rtl/tff_emit.sv
// Output sequencer: on start, fixes the frame length (pad and cap applied),
// then streams one byte per cycle from buffer byte 2 onward, zero past the
// real length. Assumes the buffer is not written while busy.
module tff_emit
    import tff_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 60,
    parameter int CNT_W     = 12,
    parameter int IDX_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] pay_len,
    input  logic             pad_en,
    input  logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             done,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last
);
    localparam int OUT_MAX = BUF_BYTES - PREFIX_BYTES;

    emit_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] olen_q;
    logic [CNT_W-1:0] rlen_q;
    logic [31:0]      raw_len, real_len, tot_len;
    logic             last_now;
    logic             zero_fill;

    // Frame length at launch: header added, capped, then padded.
    always_comb begin
        raw_len  = 32'(pay_len) + 32'(HDR_BYTES);
        real_len = (raw_len > 32'(OUT_MAX)) ? 32'(OUT_MAX) : raw_len;
        tot_len  = (pad_en && real_len < 32'(MIN_FRAME)) ? 32'(MIN_FRAME) : real_len;
    end

    // Per-byte controls while streaming.
    always_comb begin
        busy      = (state_q == EMIT_RUN);
        last_now  = busy && (CNT_W'(idx_q) + CNT_W'(1) == olen_q);
        done      = last_now;
        zero_fill = (CNT_W'(idx_q) >= rlen_q);
        rd_idx    = idx_q + IDX_W'(PREFIX_BYTES);
    end

    // Sequencer and registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= EMIT_IDLE;
            idx_q     <= '0;
            olen_q    <= '0;
            rlen_q    <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            case (state_q)
                EMIT_IDLE: begin
                    out_valid <= 1'b0;
                    out_last  <= 1'b0;
                    if (start) begin
                        state_q <= EMIT_RUN;
                        idx_q   <= '0;
                        olen_q  <= CNT_W'(tot_len);
                        rlen_q  <= CNT_W'(real_len);
                    end
                end
                default: begin
                    out_valid <= 1'b1;
                    out_data  <= zero_fill ? 8'h00 : rd_byte;
                    out_last  <= last_now;
                    idx_q     <= idx_q + IDX_W'(1);
                    if (last_now) state_q <= EMIT_IDLE;
                end
            endcase
        end
    end

    // R7: bytes of one frame come on back-to-back cycles.
    assert_stream_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R8: a padded frame never carries a nonzero byte past the real length.
    assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zero_fill) |=> (out_data == 8'h00));
endmodule

// File: rtl/tx_frame_fifo.sv
// Top of the transmit frame FIFO: ties the word store, launch decision and
// output sequencer together and keeps the two status flags.
// Assumes one word write per accepted handshake.
module tx_frame_fifo
    import tff_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int MAX_PAY   = 2032,
    parameter int MIN_FRAME = 60,
    parameter int THR_W     = 6,
    parameter int LEN_W     = 16,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              send_req,
    input  logic              crc_auto,
    input  logic              pad_en,
    input  logic [THR_W-1:0]  thr_code,
    input  logic              err_ack,
    input  logic              empty_ack,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              tx_empty,
    output logic              tx_err
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam int IDX_W = $clog2(BUF_BYTES);

    logic             busy, done, flush, wr_en, stored, reject, go, start;
    logic [CNT_W-1:0] fill_nxt;
    logic [LEN_W-1:0] len_nxt;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    // Handshake, launch and flush glue.
    always_comb begin
        wr_ready = !busy;
        wr_en    = wr_valid && wr_ready;
        start    = !busy && ((stored && go) || send_req);
        flush    = done || err_ack;
    end

    tff_store #(
        .BUF_BYTES(BUF_BYTES), .MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
        .rd_idx(rd_idx), .stored(stored), .reject(reject), .fill_nxt(fill_nxt),
        .len_nxt(len_nxt), .rd_byte(rd_byte)
    );

    tff_launch #(
        .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .THR_W(THR_W), .CNT_W(CNT_W)
    ) u_launch (
        .fill(fill_nxt), .pay_len(len_nxt), .crc_auto(crc_auto),
        .thr_code(thr_code), .go(go)
    );

    tff_emit #(
        .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_emit (
        .clk(clk), .rst_n(rst_n), .start(start), .pay_len(len_nxt), .pad_en(pad_en),
        .rd_byte(rd_byte), .rd_idx(rd_idx), .busy(busy), .done(done),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    // Status flags: a set event wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty <= 1'b0;
            tx_err   <= 1'b0;
        end else begin
            if (done)           tx_empty <= 1'b1;
            else if (empty_ack) tx_empty <= 1'b0;
            if (reject)         tx_err   <= 1'b1;
            else if (err_ack)   tx_err   <= 1'b0;
        end
    end

    // R11: no word is accepted while a frame is mid-stream.
    assert_busy_blocks_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !wr_ready);

    // R9: the last byte comes with the empty flag.
    assert_last_sets_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> tx_empty);

    // R10: an acknowledge with no new refusal clears the error flag.
    assert_err_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ack && !reject) |=> !tx_err);
endmodule

// File: tb/tx_frame_fifo_bench.sv
// Scoreboard bench: the write tasks keep a byte model of the buffer and queue
// the expected output bytes; a falling-edge monitor pops and compares them.
module tx_frame_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        send_req = 1'b0;
    logic        crc_auto = 1'b1;
    logic        pad_en = 1'b0;
    logic [5:0]  thr_code = 6'h3F;
    logic        err_ack = 1'b0;
    logic        empty_ack = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        tx_empty;
    logic        tx_err;

    always #5 clk = ~clk;

    tx_frame_fifo u_tx_frame_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .send_req(send_req), .crc_auto(crc_auto),
        .pad_en(pad_en), .thr_code(thr_code), .err_ack(err_ack),
        .empty_ack(empty_ack), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .tx_empty(tx_empty), .tx_err(tx_err)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_tag = "R7";
    logic [8:0]  exp_q [$];
    logic [7:0]  mb [2048];
    int          mcnt = 0;
    int          mlen = 0;
    int          cyc = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] pat(input int k);
        return {8'(k * 7 + 11), 8'(k * 13 + 5), 8'(k * 3 + 1), 8'(k + 200)};
    endfunction

    // Queue the expected frame from the byte model (R7, R8), then empty it (R9).
    task automatic expect_frame();
        int r, t;
        r = (mlen + 14 > 2046) ? 2046 : mlen + 14;
        t = (pad_en && r < 60) ? 60 : r;
        for (int i = 0; i < t; i++)
            exp_q.push_back({(i == t - 1), (i < r) ? mb[i + 2] : 8'h00});
        mcnt = 0;
    endtask

    // Drive one word and update the model per R1..R5.
    task automatic put(input logic [31:0] w);
        bit st = 0;
        int need;
        bit thr_ok, full_ok;
        if (mcnt == 0 && w[15:0] > 16'd2032) begin
            st = 0;
        end else if (mcnt + 4 <= 2048) begin
            for (int b = 0; b < 4; b++) mb[mcnt + b] = w[8*b +: 8];
            if (mcnt == 0) mlen = int'(w[15:0]);
            mcnt += 4;
            st = 1;
        end
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        need = mlen + 16 + (crc_auto ? 0 : 4);
        if (need > 2048) need = 2048;
        thr_ok  = (thr_code != 6'h3F) && (mcnt >= 4 * (int'(thr_code) * 8 + 1));
        full_ok = (mcnt >= need);
        if (st && thr_ok && full_ok) expect_frame();
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic header(input int len, input int seed);
        logic [31:0] p;
        p = pat(seed);
        put({p[31:16], 16'(len)});
    endtask

    task automatic force_send();
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        expect_frame();
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_q.size() != 0 || out_valid) && t < 6000) begin
            @(negedge clk);
            t++;
        end
        if (exp_q.size() != 0) begin
            check({cur_tag, " missing bytes"}, exp_q.size(), 0);
            exp_q.delete();
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic ack_err();
        @(negedge clk);
        err_ack = 1'b1;
        mcnt = 0;
        @(negedge clk);
        err_ack = 1'b0;
    endtask

    task automatic ack_empty();
        @(negedge clk);
        empty_ack = 1'b1;
        @(negedge clk);
        empty_ack = 1'b0;
    endtask

    // Monitor: every valid byte must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s: actual byte %0h expected none", cur_tag, out_data);
            end else begin
                check(cur_tag, 32'({out_last, out_data}), 32'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 wr_ready", 32'(wr_ready), 1);
        check("R12 out_valid", 32'(out_valid), 0);
        check("R12 tx_err", 32'(tx_err), 0);
        check("R12 tx_empty", 32'(tx_empty), 0);

        // R6/R7: threshold off, full frame held, then forced out
        cur_tag = "R6 forced send";
        thr_code = 6'h3F; crc_auto = 1'b1; pad_en = 1'b0;
        header(20, 1);
        for (int k = 2; k <= 9; k++) put(pat(k));
        check("R5 no launch with threshold off", 32'(out_valid), 0);
        force_send();
        drain();
        check("R9 empty flag set", 32'(tx_empty), 1);
        ack_empty();
        check("R9 empty flag cleared", 32'(tx_empty), 0);

        // R8: padded short frame, auto launch with threshold code 0
        cur_tag = "R8 padding";
        thr_code = 6'd0; pad_en = 1'b1;
        header(10, 20);
        for (int k = 21; k <= 26; k++) put(pat(k));
        drain();

        // R3: checksum space required when crc_auto is 0
        cur_tag = "R3 completeness";
        pad_en = 1'b0; crc_auto = 1'b0;
        header(10, 40);
        for (int k = 41; k <= 46; k++) put(pat(k));
        check("R3 no launch one word short", 32'(out_valid | !wr_ready), 0);
        put(pat(47));
        drain();

        // R4/R5: threshold code 2 needs 68 bytes
        cur_tag = "R4 threshold";
        crc_auto = 1'b1; thr_code = 6'd2;
        header(40, 60);
        for (int k = 61; k <= 75; k++) put(pat(k));
        check("R4 no launch below threshold", 32'(out_valid | !wr_ready), 0);
        put(pat(76));
        check("R11 wr_ready low while sending", 32'(wr_ready), 0);
        drain();

        // R1: oversize header refused and not stored
        cur_tag = "R1 after refusal";
        thr_code = 6'd0;
        header(2033, 80);
        check("R1 tx_err set", 32'(tx_err), 1);
        header(4, 81);
        for (int k = 82; k <= 85; k++) put(pat(k));
        drain();
        ack_err();
        check("R10 tx_err cleared", 32'(tx_err), 0);

        // R1 boundary and R10 flush
        cur_tag = "R10 flush";
        thr_code = 6'h3F;
        header(2032, 90);
        check("R1 2032 accepted", 32'(tx_err), 0);
        ack_err();
        thr_code = 6'd0;
        header(4, 95);
        for (int k = 96; k <= 99; k++) put(pat(k));
        drain();

        // R2: fill the buffer, one extra word dropped, then force out
        cur_tag = "R2 full buffer";
        thr_code = 6'h3F; crc_auto = 1'b0;
        header(2032, 100);
        for (int k = 1; k <= 512; k++) put(pat(100 + k));
        check("R2 no launch when full", 32'(out_valid), 0);
        force_send();
        drain();

        finish_run();
    end
endmodule